// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the integer registers of a 32-bit core that runs in eight processor modes. Software always names registers 0 to 15. The active mode decides which physical copy stands behind each name.

- Registers 0 to 7 and register 15 (the program counter) have one copy that every mode shares.
- The fast-interrupt mode has its own copies of registers 8 to 14.
- Five further exception modes have their own copies of only registers 13 and 14.
- User and System modes share one set.

Every banked exception mode also owns a saved status word. A single current status word is shared by all modes.

The core drives the mode input along with two combinational read ports and one write port, all addressed by register number. A separate path reads and writes the saved status word of the current mode. A debug port names a mode of its own and reaches that mode's registers directly, whatever mode the core is in. A read that targets the register being written in the same cycle returns the new value.

All pins are plain control and data signals. The block never stalls, so it has no valid/ready handshake and no back-pressure.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register, the program counter, every saved status word and the current status word read as zero.
- R2: Registers 0 to 7 are one set shared by all modes. A value written in any mode is read back in every mode.
- R3: Registers 8 to 12 have a private copy in fast-interrupt mode (code 10001). Every other mode sees the User copy.
- R4: Registers 13 and 14 have a private copy in each of fast-interrupt (10001), IRQ (10010), Supervisor (10011), Monitor (10110), Abort (10111) and Undefined (11011) modes. User (10000), System (11111) and any unlisted code share the User copy.
- R5: Register 15 is one program counter shared by all modes.
- R6: Each of the six banked modes in R4 has its own saved status word. In User, System or an unlisted code the saved status path reads zero, and a write there changes nothing.
- R7: The current status word is one register shared by all modes. A write is visible from the next cycle on.
- R8: A read (either read port, debug read, saved status or current status) that targets the register being written in the same cycle returns the write data.
- R9: A write uses the mode present in the same cycle. If the mode changes and a write happens in the same cycle, the write lands only in the new mode's bank.
- R10: The debug port reads and writes the bank of its own named mode, not the current mode. If it writes the same physical register as the main write port in the same cycle, the main write wins.
- R11: The two read ports are independent. Each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode code |
| rd0_idx | input | 4 | Read port 0 register number |
| rd0_data | output | 32 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 register number |
| rd1_data | output | 32 | Read port 1 data |
| wr_en | input | 1 | Main write enable |
| wr_idx | input | 4 | Main write register number |
| wr_data | input | 32 | Main write data |
| saved_rdata | output | 32 | Saved status word of the current mode |
| saved_we | input | 1 | Saved status write enable |
| saved_wdata | input | 32 | Saved status write data |
| status_rdata | output | 32 | Current status word |
| status_we | input | 1 | Current status write enable |
| status_wdata | input | 32 | Current status write data |
| dbg_mode | input | 5 | Mode whose bank the debug port reaches |
| dbg_idx | input | 4 | Debug register number |
| dbg_rdata | output | 32 | Debug read data |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |

## Verification
All read results are combinational, so they are due in the cycle of the stimulus. The bench drives inputs just after the falling edge and samples one nanosecond later, before the next rising edge. It checks the same-cycle bypass while the write is still asserted, in that same window. A write becomes visible through storage from the cycle after its rising edge, so every readback is placed at least one falling edge after the write was released. A full sweep writes all sixteen registers in all eight modes, then reads every mode and register pair. The expected value comes from the last mode in the write order that shares that register.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned MODE_W  = 5;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned FIQ_LO  = 8;   // first register private to fast-interrupt mode
  localparam int unsigned HI_LO   = 13;  // first register private to every banked mode
  localparam int unsigned PC_IDX  = 15;
  localparam int unsigned N_USER  = PC_IDX;            // user copies of r0..r14
  localparam int unsigned N_FIQ   = PC_IDX - FIQ_LO;   // r8..r14
  localparam int unsigned N_HI    = PC_IDX - HI_LO;    // r13..r14
  localparam int unsigned N_PRIV  = 5;                 // modes banking only r13/r14
  localparam int unsigned N_PHYS  = N_USER + N_FIQ + N_PRIV * N_HI;
  localparam int unsigned PHYS_W  = $clog2(N_PHYS);
  localparam int unsigned N_SAVED = N_PRIV + 1;
  localparam int unsigned SAVED_W = $clog2(N_SAVED);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_MON = 5'b10110;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_MON
  } bank_e;

  function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BK_FIQ;
      M_IRQ:   return BK_IRQ;
      M_SVC:   return BK_SVC;
      M_ABT:   return BK_ABT;
      M_UND:   return BK_UND;
      M_MON:   return BK_MON;
      default: return BK_USR;  // user, system and unlisted codes
    endcase
  endfunction
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc,
  output bank_e             bank
);
  int unsigned slot;

  always_comb begin
    bank  = mode_to_bank(mode);
    is_pc = (32'(idx) == PC_IDX);
    slot  = 32'(idx);
    if (is_pc) begin
      slot = 0;
    end else if (32'(idx) >= FIQ_LO && bank == BK_FIQ) begin
      slot = N_USER + 32'(idx) - FIQ_LO;
    end else if (32'(idx) >= HI_LO && bank >= BK_IRQ) begin
      slot = N_USER + N_FIQ + (32'(bank) - 32'(BK_IRQ)) * N_HI + 32'(idx) - HI_LO;
    end
    phys = PHYS_W'(slot);
  end
endmodule

// File: rtl/rf_gpr_store.sv
module rf_gpr_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_ENT  = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_RD   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          a_we,
  input  logic [ADDR_W-1:0]             a_addr,
  input  logic [DATA_W-1:0]             a_data,
  input  logic                          b_we,
  input  logic [ADDR_W-1:0]             b_addr,
  input  logic [DATA_W-1:0]             b_data,
  input  logic [N_RD-1:0][ADDR_W-1:0]   raddr,
  output logic [N_RD-1:0][DATA_W-1:0]   rdata
);
  logic [N_ENT-1:0][DATA_W-1:0] mem_q;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (a_we && a_addr == ADDR_W'(e)) begin
        mem_q[e] <= a_data;   // main port has priority
      end else if (b_we && b_addr == ADDR_W'(e)) begin
        mem_q[e] <= b_data;
      end
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rdata[r] = (a_we && a_addr == raddr[r]) ? a_data :
                      (b_we && b_addr == raddr[r]) ? b_data : mem_q[raddr[r]];
  end

  // R10: on a same-entry collision the main port's data is what lands
  a_r10_main_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && a_addr == b_addr) |=> mem_q[$past(a_addr)] == $past(a_data));

  // R9: a written entry holds the written data after the edge
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> mem_q[$past(a_addr)] == $past(a_data));
endmodule

// File: rtl/rf_saved_sr.sv
module rf_saved_sr
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [N_SAVED-1:0][DATA_W-1:0] sr_q;
  logic                           has_slot;
  logic [SAVED_W-1:0]             slot;

  assign has_slot = (bank != BK_USR);
  assign slot     = SAVED_W'(32'(bank) - 1);

  for (genvar s = 0; s < N_SAVED; s++) begin : g_sr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sr_q[s] <= '0;
      end else if (we && has_slot && slot == SAVED_W'(s)) begin
        sr_q[s] <= wdata;
      end
    end
  end

  assign rdata = !has_slot ? '0 : (we ? wdata : sr_q[slot]);

  // R6: user/system view reads zero
  a_r6_user_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bank == BK_USR) |-> rdata == '0);

  // R6: a write from the user/system view leaves every saved word untouched
  a_r6_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bank == BK_USR) |=> $stable(sr_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [3:0]        rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] saved_rdata,
  input  logic              saved_we,
  input  logic [DATA_W-1:0] saved_wdata,
  output logic [DATA_W-1:0] status_rdata,
  input  logic              status_we,
  input  logic [DATA_W-1:0] status_wdata,
  input  logic [4:0]        dbg_mode,
  input  logic [3:0]        dbg_idx,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata
);
  localparam int unsigned N_PORT = 3;   // rd0, rd1, debug
  localparam int unsigned P_DBG  = 2;

  logic [N_PORT-1:0][MODE_W-1:0] p_mode;
  logic [N_PORT-1:0][IDX_W-1:0]  p_idx;
  logic [N_PORT-1:0][PHYS_W-1:0] p_phys;
  logic [N_PORT-1:0]             p_is_pc;
  bank_e                         p_bank [N_PORT];
  logic [N_PORT-1:0][DATA_W-1:0] p_store;
  logic [N_PORT-1:0][DATA_W-1:0] p_data;

  logic [PHYS_W-1:0] w_phys;
  logic              w_is_pc;
  bank_e             w_bank;
  logic [DATA_W-1:0] pc_q, pc_view, status_q;

  assign p_mode = {dbg_mode, mode_i, mode_i};
  assign p_idx  = {dbg_idx, rd1_idx, rd0_idx};

  for (genvar k = 0; k < N_PORT; k++) begin : g_map
    rf_bank_map u_map (
      .mode (p_mode[k]),
      .idx  (p_idx[k]),
      .phys (p_phys[k]),
      .is_pc(p_is_pc[k]),
      .bank (p_bank[k])
    );
    assign p_data[k] = p_is_pc[k] ? pc_view : p_store[k];
  end

  rf_bank_map u_wmap (
    .mode (mode_i),
    .idx  (wr_idx),
    .phys (w_phys),
    .is_pc(w_is_pc),
    .bank (w_bank)
  );

  rf_gpr_store #(
    .DATA_W(DATA_W), .N_ENT(N_PHYS), .ADDR_W(PHYS_W), .N_RD(N_PORT)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .a_we  (wr_en && !w_is_pc),
    .a_addr(w_phys),
    .a_data(wr_data),
    .b_we  (dbg_we && !p_is_pc[P_DBG]),
    .b_addr(p_phys[P_DBG]),
    .b_data(dbg_wdata),
    .raddr (p_phys),
    .rdata (p_store)
  );

  rf_saved_sr #(.DATA_W(DATA_W)) u_saved (
    .clk  (clk),
    .rst_n(rst_n),
    .bank (w_bank),
    .we   (saved_we),
    .wdata(saved_wdata),
    .rdata(saved_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      status_q <= '0;
    end else begin
      if (wr_en && w_is_pc) begin
        pc_q <= wr_data;
      end else if (dbg_we && p_is_pc[P_DBG]) begin
        pc_q <= dbg_wdata;
      end
      if (status_we) begin
        status_q <= status_wdata;
      end
    end
  end

  assign pc_view      = (wr_en && w_is_pc) ? wr_data :
                        (dbg_we && p_is_pc[P_DBG]) ? dbg_wdata : pc_q;
  assign status_rdata = status_we ? status_wdata : status_q;
  assign rd0_data     = p_data[0];
  assign rd1_data     = p_data[1];
  assign dbg_rdata    = p_data[P_DBG];

  // R8: both read ports forward the write data of the same cycle
  a_r8_rd0_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd0_idx == wr_idx) |-> rd0_data == wr_data);
  a_r8_rd1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd1_idx == wr_idx) |-> rd1_data == wr_data);

  // R5: a program-counter write is seen in the next cycle whatever the mode
  a_r5_pc_shared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_idx) == 4'd15 && !wr_en && !dbg_we && rd0_idx == 4'd15)
    |-> rd0_data == $past(wr_data));

  // R7: the current status word holds what was last written
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_we ##1 !status_we) |-> status_rdata == $past(status_wdata));
endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode_i, dbg_mode;
  logic [3:0]  rd0_idx, rd1_idx, wr_idx, dbg_idx;
  logic [31:0] rd0_data, rd1_data, wr_data, saved_rdata, saved_wdata;
  logic [31:0] status_rdata, status_wdata, dbg_rdata, dbg_wdata;
  logic        wr_en, saved_we, status_we, dbg_we;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [4:0] MODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                      5'b11011, 5'b10111, 5'b11111, 5'b10110};

  always #2 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .saved_rdata(saved_rdata), .saved_we(saved_we), .saved_wdata(saved_wdata),
    .status_rdata(status_rdata), .status_we(status_we), .status_wdata(status_wdata),
    .dbg_mode(dbg_mode), .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkval(input int w, input int i);
    return 32'hC0DE_0000 | 32'(w << 8) | 32'(i);
  endfunction

  function automatic bit is_fiq(input logic [4:0] m);
    return m == 5'b10001;
  endfunction

  function automatic logic [4:0] canon(input logic [4:0] m);
    return (m == 5'b11111) ? 5'b10000 : m;
  endfunction

  function automatic bit shares(input logic [4:0] a, input logic [4:0] b, input int i);
    if (i < 8 || i == 15) return 1'b1;
    if (i < 13) return is_fiq(a) == is_fiq(b);
    return canon(a) == canon(b);
  endfunction

  function automatic logic [31:0] sweep_exp(input int m, input int i);
    int last = m;
    for (int w = 0; w < 8; w++) if (shares(MODES[w], MODES[m], i)) last = w;
    return mkval(last, i);
  endfunction

  function automatic string tag_of(input int i);
    if (i < 8) return "R2";
    if (i < 13) return "R3";
    if (i < 15) return "R4";
    return "R5";
  endfunction

  task automatic idle();
    wr_en = 0; saved_we = 0; status_we = 0; dbg_we = 0;
  endtask

  task automatic write_reg(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    mode_i = m; wr_idx = i; wr_data = d; wr_en = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic read_at(input logic [4:0] m, input logic [3:0] i0, input logic [3:0] i1);
    @(negedge clk);
    mode_i = m; rd0_idx = i0; rd1_idx = i1;
    #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<200000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    mode_i = 5'b10000; dbg_mode = 5'b10000; rd0_idx = 0; rd1_idx = 0; wr_idx = 0; dbg_idx = 0;
    wr_data = 0; saved_wdata = 0; status_wdata = 0; dbg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      read_at(5'b10000, 4'(i), 4'(15 - i));
      chk(rd0_data, 32'h0, "R1 reg after reset");
    end
    read_at(5'b10001, 0, 0);
    chk(saved_rdata, 32'h0, "R1 saved after reset");
    chk(status_rdata, 32'h0, "R1 status after reset");

    // sweep: every mode writes every register and its saved word
    for (int w = 0; w < 8; w++) begin
      for (int i = 0; i < 16; i++) write_reg(MODES[w], 4'(i), mkval(w, i));
      @(negedge clk);
      mode_i = MODES[w]; saved_wdata = 32'h5A00_0000 | 32'(w); saved_we = 1;
      @(negedge clk);
      idle();
    end

    // R2 R3 R4 R5 R11 R6: read every mode/register pair on both ports
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 16; i++) begin
        read_at(MODES[m], 4'(i), 4'(15 - i));
        chk(rd0_data, sweep_exp(m, i), tag_of(i));
        chk(rd1_data, sweep_exp(m, 15 - i), {tag_of(15 - i), " R11 port1"});
      end
      chk(saved_rdata, (MODES[m] == 5'b10000 || MODES[m] == 5'b11111) ? 32'h0
                       : (32'h5A00_0000 | 32'(m)), "R6 saved per mode");
    end

    // R4 R6: an unlisted mode code behaves as user
    read_at(5'b00000, 13, 9);
    chk(rd0_data, sweep_exp(0, 13), "R4 unlisted mode r13");
    chk(saved_rdata, 32'h0, "R6 unlisted mode saved");

    // R6: user write ignored, fast-interrupt saved word unchanged
    @(negedge clk);
    mode_i = 5'b10000; saved_wdata = 32'hDEAD_BEEF; saved_we = 1;
    @(negedge clk); idle(); #1;
    chk(saved_rdata, 32'h0, "R6 user saved write ignored");
    read_at(5'b10001, 0, 0);
    chk(saved_rdata, 32'h5A00_0001, "R6 other saved untouched");

    // R8: same-cycle bypass on both ports and the saved word
    @(negedge clk);
    mode_i = 5'b10010; wr_idx = 13; wr_data = 32'h1111_2222; wr_en = 1;
    rd0_idx = 13; rd1_idx = 13; saved_wdata = 32'h7777_0002; saved_we = 1;
    #1;
    chk(rd0_data, 32'h1111_2222, "R8 bypass port0");
    chk(rd1_data, 32'h1111_2222, "R8 bypass port1");
    chk(saved_rdata, 32'h7777_0002, "R8 saved bypass");
    @(negedge clk); idle();

    // R9: mode change and write in the same cycle
    read_at(5'b10000, 9, 9);
    @(negedge clk);
    mode_i = 5'b10001; wr_idx = 9; wr_data = 32'h9999_0009; wr_en = 1;
    @(negedge clk); idle();
    read_at(5'b10001, 9, 9);
    chk(rd0_data, 32'h9999_0009, "R9 write in new bank");
    read_at(5'b10000, 9, 9);
    chk(rd0_data, sweep_exp(0, 9), "R9 old bank untouched");

    // R10: debug port reaches a named bank independent of mode_i
    @(negedge clk);
    mode_i = 5'b10000; dbg_mode = 5'b10011; dbg_idx = 13; #1;
    chk(dbg_rdata, sweep_exp(3, 13), "R10 debug read svc r13");
    dbg_mode = 5'b10111; dbg_idx = 14; dbg_wdata = 32'hABCD_0014; dbg_we = 1;
    @(negedge clk); idle();
    read_at(5'b10111, 14, 14);
    chk(rd0_data, 32'hABCD_0014, "R10 debug write lands in abort r14");
    read_at(5'b10000, 14, 14);
    chk(rd0_data, sweep_exp(0, 14), "R10 user r14 untouched");

    // R10: collision, main write wins
    @(negedge clk);
    mode_i = 5'b10011; wr_idx = 13; wr_data = 32'hAAAA_0000; wr_en = 1;
    dbg_mode = 5'b10011; dbg_idx = 13; dbg_wdata = 32'hBBBB_0000; dbg_we = 1;
    #1;
    chk(dbg_rdata, 32'hAAAA_0000, "R10 collision debug read");
    @(negedge clk); idle();
    read_at(5'b10011, 13, 13);
    chk(rd0_data, 32'hAAAA_0000, "R10 collision main wins");

    // R7: current status shared, visible next cycle
    @(negedge clk);
    mode_i = 5'b10001; status_wdata = 32'h600D_0007; status_we = 1;
    #1;
    chk(status_rdata, 32'h600D_0007, "R8 status bypass");
    @(negedge clk); idle();
    for (int m = 0; m < 8; m++) begin
      read_at(MODES[m], 0, 0);
      chk(status_rdata, 32'h600D_0007, "R7 status shared");
    end

    // R5: debug write to r15 seen by all modes
    @(negedge clk);
    dbg_mode = 5'b10110; dbg_idx = 15; dbg_wdata = 32'h0000_F00C; dbg_we = 1;
    @(negedge clk); idle();
    read_at(5'b10010, 15, 15);
    chk(rd0_data, 32'h0000_F00C, "R5 pc after debug write");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule